// File: doc/BRIEF.md
# ECC Error Response Controller

This block sits in the SDRAM data path of a memory controller, between the host bus side and the memory array. Each memory beat arrives with its SEC-DED check bits. The block decodes the beat and sorts it into one of three classes: clean, single-bit or multi-bit. It then acts according to the access type the beat belongs to. There are five access types: a one-word read, a four-beat line read, a one-word write carried out as read-modify-write, a full-line write, and a background scrub.

The outputs are a read-data beat for the requester, a write-back word with freshly generated check bits, a normal bus termination, an error interrupt and a machine-check request. A sticky status record keeps the most severe error seen since software last cleared it. The record holds the error class, the access type, the address and the syndrome. The interrupt and the machine-check request are level signals derived from this record. Three separate enables gate the interrupt, the machine check and scrub write-back.

Top module: `ecc_resp_ctrl`

## Requirements
- R1: The code words use Hamming order. Data bit j occupies the j-th position, counting from 1, that is not a power of two. Check bit i (i < HAM_W) is the XOR of every data bit whose position has bit i set. The top check bit is the XOR of all data bits and all lower check bits. Every write-back carries check bits generated this way from its own data.
- R2: A beat is clean when the syndrome is zero and the overall parity is even. It is single-bit when the overall parity is odd and the syndrome is zero or names a valid position. It is multi-bit in every other case. The class is recorded as 0 = clean, 1 = single-bit, 2 = multi-bit.
- R3: On a one-word or line read that is clean or single-bit, rd_data is the corrected word.
- R4: On a read with a multi-bit error, rd_data is the raw memory word. The machine-check flag is set.
- R5: On a one-word write that is clean or single-bit, the corrected memory word is merged with wr_data. Bit l of wr_be selects byte lane l from wr_data. The merged word is then written back.
- R6: On a one-word write with a multi-bit error, no write-back is issued.
- R7: A scrub beat produces no bus_ack and no rd_valid. A single-bit scrub writes the corrected word back only when scrub_wb_en is 1. A multi-bit scrub writes nothing back. A scrub never sets the machine-check flag.
- R8: Every host beat (access types 0 to 3) gets bus_ack, whatever its error class. No error termination exists. A full-line write (type 3) is not checked and writes wr_data back.
- R9: In a line read, each beat is corrected or passed raw on its own. The status keeps the worst class seen across the beats.
- R10: Any checked beat that has an error sets st_sbe or st_mbe. The class, type, address and syndrome are captured only when the new class is more severe than the held class. The held class returns to 0 once both st_sbe and st_mbe are cleared.
- R11: irq equals irq_en AND (st_sbe OR st_mbe). mchk equals mchk_en AND st_mck. st_clr bits 0, 1 and 2 clear st_sbe, st_mbe and st_mck (write-one-to-clear). A new error in the same cycle as a clear wins over the clear.
- R12: Outputs appear one clock after the beat is presented. After reset every output and every status field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| beat_valid | input | 1 | A beat is presented this cycle |
| beat_kind | input | 3 | Access type: 0 one-word read, 1 line read, 2 one-word write, 3 full-line write, 4 scrub |
| beat_addr | input | ADDR_W | Address of the beat |
| mem_data | input | DATA_W | Data word read from SDRAM |
| mem_chk | input | CHK_W | Check bits read from SDRAM |
| wr_data | input | DATA_W | Write data from the bus |
| wr_be | input | DATA_W/LANE_W | Byte-lane enables for the merge |
| irq_en | input | 1 | Error interrupt enable |
| mchk_en | input | 1 | Machine-check enable |
| scrub_wb_en | input | 1 | Scrub write-back enable |
| st_clr | input | 3 | Write-one-to-clear for sbe, mbe, mck |
| bus_ack | output | 1 | Normal termination of a host beat |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Corrected or raw read data |
| wb_valid | output | 1 | Write-back request |
| wb_addr | output | ADDR_W | Write-back address |
| wb_data | output | DATA_W | Write-back data |
| wb_chk | output | CHK_W | Write-back check bits |
| irq | output | 1 | Error interrupt level |
| mchk | output | 1 | Machine-check request level |
| st_sbe | output | 1 | Sticky single-bit error flag |
| st_mbe | output | 1 | Sticky multi-bit error flag |
| st_mck | output | 1 | Sticky machine-check cause flag |
| st_cls | output | 2 | Held error class |
| st_kind | output | 3 | Access type of the held error |
| st_addr | output | ADDR_W | Address of the held error |
| st_syn | output | CHK_W | Syndrome of the held error, overall parity at the top |

## Verification
The bench flips every single bit of the 22-bit code word and every pair of bits, across several data patterns. A decoder that mistook a check-bit flip for a data-bit flip would corrupt rd_data. A decoder that mislabelled a pair would either "correct" the wrong bit or miss the machine check. Read-modify-write is swept over every byte-enable pattern combined with every single flip, which exposes merges that take lanes from the raw word or write stale check bits. Scrub is run with write-back enabled and disabled. A line read mixes clean, single-bit and multi-bit beats, which catches status logic that lets a later single-bit error overwrite a held multi-bit record. The enables and partial clears are toggled while errors are held, which catches edge-triggered or ungated interrupt levels.

// File: rtl/ecc_resp_pkg.sv
package ecc_resp_pkg;

    typedef enum logic [2:0] {
        KIND_RD_ONE  = 3'd0,
        KIND_RD_LINE = 3'd1,
        KIND_WR_ONE  = 3'd2,
        KIND_WR_LINE = 3'd3,
        KIND_SCRUB   = 3'd4
    } acc_kind_e;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_SGL   = 2'd1,
        CLS_MULTI = 2'd2
    } err_cls_e;

    // number of Hamming parity bits needed for dw data bits
    function automatic int ham_bits(input int dw);
        for (int k = 1; k < 16; k++) begin
            if ((1 << k) >= dw + k + 1) return k;
        end
        return 16;
    endfunction

    // code position (1-based) of data bit idx: skips powers of two
    function automatic int data_pos(input int idx);
        int cnt;
        cnt = 0;
        for (int p = 3; p < 4096; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == idx) return p;
                cnt++;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc
    import ecc_resp_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int HAM_W = ham_bits(DATA_W),
    localparam int CHK_W = HAM_W + 1
) (
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  chk
);

    logic [HAM_W-1:0][DATA_W-1:0] sel;
    logic [HAM_W-1:0]             ham;

    for (genvar p = 0; p < HAM_W; p++) begin : g_par
        for (genvar j = 0; j < DATA_W; j++) begin : g_bit
            localparam int POS = data_pos(j);
            assign sel[p][j] = ((POS >> p) & 1) != 0 ? data[j] : 1'b0;
        end
        assign ham[p] = ^sel[p];
    end

    assign chk = {(^data) ^ (^ham), ham};

endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec
    import ecc_resp_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int HAM_W = ham_bits(DATA_W),
    localparam int CHK_W = HAM_W + 1
) (
    input  logic [DATA_W-1:0] data,
    input  logic [CHK_W-1:0]  chk,
    output logic [DATA_W-1:0] fixed,
    output err_cls_e          cls,
    output logic [CHK_W-1:0]  syn
);

    localparam logic [HAM_W-1:0] MAX_POS = HAM_W'(data_pos(DATA_W - 1));

    logic [CHK_W-1:0]  recalc;
    logic [HAM_W-1:0]  syn_h;
    logic              par_odd;
    logic [DATA_W-1:0] flip;

    ecc_secded_enc #(.DATA_W(DATA_W)) i_enc (
        .data (data),
        .chk  (recalc)
    );

    assign syn_h   = recalc[HAM_W-1:0] ^ chk[HAM_W-1:0];
    assign par_odd = (^data) ^ (^chk);
    assign syn     = {par_odd, syn_h};

    always_comb begin
        if (!par_odd) begin
            cls = (syn_h == '0) ? CLS_NONE : CLS_MULTI;
        end else begin
            cls = (syn_h <= MAX_POS) ? CLS_SGL : CLS_MULTI;
        end
    end

    for (genvar j = 0; j < DATA_W; j++) begin : g_flip
        localparam logic [HAM_W-1:0] POS_V = HAM_W'(data_pos(j));
        assign flip[j] = (cls == CLS_SGL) && (syn_h == POS_V);
    end

    assign fixed = data ^ flip;

endmodule

// File: rtl/ecc_resp_log.sv
module ecc_resp_log
    import ecc_resp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CHK_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  err_cls_e          ev_cls,
    input  acc_kind_e         ev_kind,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [CHK_W-1:0]  ev_syn,
    input  logic              ev_mck,
    input  logic [2:0]        clr,
    input  logic              irq_en,
    input  logic              mchk_en,
    output logic              irq,
    output logic              mchk,
    output logic              st_sbe,
    output logic              st_mbe,
    output logic              st_mck,
    output logic [1:0]        st_cls,
    output logic [2:0]        st_kind,
    output logic [ADDR_W-1:0] st_addr,
    output logic [CHK_W-1:0]  st_syn
);

    typedef struct packed {
        logic              sbe;
        logic              mbe;
        logic              mck;
        err_cls_e          cls;
        acc_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic [CHK_W-1:0]  syn;
    } log_t;

    log_t log_d, log_q;

    always_comb begin
        log_d = log_q;
        if (clr[0]) log_d.sbe = 1'b0;
        if (clr[1]) log_d.mbe = 1'b0;
        if (clr[2]) log_d.mck = 1'b0;
        if (!log_d.sbe && !log_d.mbe) log_d.cls = CLS_NONE;
        if (ev_valid && ev_cls != CLS_NONE) begin
            if (ev_cls == CLS_SGL) log_d.sbe = 1'b1;
            else                   log_d.mbe = 1'b1;
            if (ev_mck)            log_d.mck = 1'b1;
            if (ev_cls > log_d.cls) begin
                log_d.cls  = ev_cls;
                log_d.kind = ev_kind;
                log_d.addr = ev_addr;
                log_d.syn  = ev_syn;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) log_q <= '0;
        else        log_q <= log_d;
    end

    assign irq     = irq_en && (log_q.sbe || log_q.mbe);
    assign mchk    = mchk_en && log_q.mck;
    assign st_sbe  = log_q.sbe;
    assign st_mbe  = log_q.mbe;
    assign st_mck  = log_q.mck;
    assign st_cls  = log_q.cls;
    assign st_kind = log_q.kind;
    assign st_addr = log_q.addr;
    assign st_syn  = log_q.syn;

endmodule

// File: rtl/ecc_resp_ctrl.sv
module ecc_resp_ctrl
    import ecc_resp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int LANE_W = 8,
    localparam int HAM_W = ham_bits(DATA_W),
    localparam int CHK_W = HAM_W + 1,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid,
    input  logic [2:0]        beat_kind,
    input  logic [ADDR_W-1:0] beat_addr,
    input  logic [DATA_W-1:0] mem_data,
    input  logic [CHK_W-1:0]  mem_chk,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    input  logic              irq_en,
    input  logic              mchk_en,
    input  logic              scrub_wb_en,
    input  logic [2:0]        st_clr,
    output logic              bus_ack,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    output logic [CHK_W-1:0]  wb_chk,
    output logic              irq,
    output logic              mchk,
    output logic              st_sbe,
    output logic              st_mbe,
    output logic              st_mck,
    output logic [1:0]        st_cls,
    output logic [2:0]        st_kind,
    output logic [ADDR_W-1:0] st_addr,
    output logic [CHK_W-1:0]  st_syn
);

    typedef struct packed {
        logic              ack;
        logic              rd_v;
        logic [DATA_W-1:0] rd_data;
        logic              wb_v;
        logic [ADDR_W-1:0] wb_addr;
        logic [DATA_W-1:0] wb_data;
        logic [CHK_W-1:0]  wb_chk;
    } out_t;

    out_t              out_d, out_q;
    acc_kind_e         kind;
    err_cls_e          dec_cls;
    logic [DATA_W-1:0] fixed;
    logic [CHK_W-1:0]  dec_syn;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] wb_src;
    logic [CHK_W-1:0]  wb_src_chk;
    logic              ev_valid;
    logic              ev_mck;

    assign kind = acc_kind_e'(beat_kind);

    ecc_secded_dec #(.DATA_W(DATA_W)) i_dec (
        .data  (mem_data),
        .chk   (mem_chk),
        .fixed (fixed),
        .cls   (dec_cls),
        .syn   (dec_syn)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged[l*LANE_W +: LANE_W] = wr_be[l] ? wr_data[l*LANE_W +: LANE_W]
                                                     : fixed[l*LANE_W +: LANE_W];
    end

    always_comb begin
        case (kind)
            KIND_WR_LINE: wb_src = wr_data;
            KIND_SCRUB:   wb_src = fixed;
            default:      wb_src = merged;
        endcase
    end

    ecc_secded_enc #(.DATA_W(DATA_W)) i_wb_enc (
        .data (wb_src),
        .chk  (wb_src_chk)
    );

    always_comb begin
        out_d    = '0;
        ev_valid = 1'b0;
        ev_mck   = 1'b0;
        if (beat_valid) begin
            case (kind)
                KIND_RD_ONE, KIND_RD_LINE: begin
                    out_d.ack     = 1'b1;
                    out_d.rd_v    = 1'b1;
                    out_d.rd_data = (dec_cls == CLS_MULTI) ? mem_data : fixed;
                    ev_valid      = 1'b1;
                    ev_mck        = (dec_cls == CLS_MULTI);
                end
                KIND_WR_ONE: begin
                    out_d.ack = 1'b1;
                    ev_valid  = 1'b1;
                    ev_mck    = (dec_cls == CLS_MULTI);
                    if (dec_cls != CLS_MULTI) begin
                        out_d.wb_v    = 1'b1;
                        out_d.wb_addr = beat_addr;
                        out_d.wb_data = wb_src;
                        out_d.wb_chk  = wb_src_chk;
                    end
                end
                KIND_WR_LINE: begin
                    out_d.ack     = 1'b1;
                    out_d.wb_v    = 1'b1;
                    out_d.wb_addr = beat_addr;
                    out_d.wb_data = wb_src;
                    out_d.wb_chk  = wb_src_chk;
                end
                KIND_SCRUB: begin
                    ev_valid = 1'b1;
                    if (dec_cls == CLS_SGL && scrub_wb_en) begin
                        out_d.wb_v    = 1'b1;
                        out_d.wb_addr = beat_addr;
                        out_d.wb_data = wb_src;
                        out_d.wb_chk  = wb_src_chk;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign bus_ack  = out_q.ack;
    assign rd_valid = out_q.rd_v;
    assign rd_data  = out_q.rd_data;
    assign wb_valid = out_q.wb_v;
    assign wb_addr  = out_q.wb_addr;
    assign wb_data  = out_q.wb_data;
    assign wb_chk   = out_q.wb_chk;

    ecc_resp_log #(.ADDR_W(ADDR_W), .CHK_W(CHK_W)) i_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_valid (ev_valid),
        .ev_cls   (dec_cls),
        .ev_kind  (kind),
        .ev_addr  (beat_addr),
        .ev_syn   (dec_syn),
        .ev_mck   (ev_mck),
        .clr      (st_clr),
        .irq_en   (irq_en),
        .mchk_en  (mchk_en),
        .irq      (irq),
        .mchk     (mchk),
        .st_sbe   (st_sbe),
        .st_mbe   (st_mbe),
        .st_mck   (st_mck),
        .st_cls   (st_cls),
        .st_kind  (st_kind),
        .st_addr  (st_addr),
        .st_syn   (st_syn)
    );

endmodule

// File: rtl/ecc_resp_ctrl_chk.sv
module ecc_resp_ctrl_chk
    import ecc_resp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       beat_valid,
    input logic [2:0] beat_kind,
    input logic [1:0] dec_cls,
    input logic       bus_ack,
    input logic       rd_valid,
    input logic       wb_valid,
    input logic       irq,
    input logic       irq_en,
    input logic [2:0] st_clr,
    input logic       st_mbe,
    input logic       st_mck
);

    p_multi_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && dec_cls == CLS_MULTI && beat_kind != KIND_WR_LINE && beat_kind <= KIND_SCRUB
        |=> st_mbe);

    p_rmw_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_kind == KIND_WR_ONE && dec_cls == CLS_MULTI |=> !wb_valid);

    p_scrub_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_kind == KIND_SCRUB |=> !bus_ack && !rd_valid);

    p_mck_host_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_mck) |-> $past(beat_valid) && $past(beat_kind) != KIND_SCRUB);

    p_ack_host_r8: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_kind <= KIND_WR_LINE |=> bus_ack);

    p_mbe_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_mbe && !st_clr[1] |=> st_mbe);

    p_irq_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(|st_clr) || !irq_en);

    p_rd_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(beat_valid) &&
                     ($past(beat_kind) == KIND_RD_ONE || $past(beat_kind) == KIND_RD_LINE));

endmodule

bind ecc_resp_ctrl ecc_resp_ctrl_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (beat_valid),
    .beat_kind  (beat_kind),
    .dec_cls    (dec_cls),
    .bus_ack    (bus_ack),
    .rd_valid   (rd_valid),
    .wb_valid   (wb_valid),
    .irq        (irq),
    .irq_en     (irq_en),
    .st_clr     (st_clr),
    .st_mbe     (st_mbe),
    .st_mck     (st_mck)
);

// File: tb/test_ecc_resp_ctrl.sv
module test_ecc_resp_ctrl;

    localparam int DW = 16;
    localparam int AW = 8;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          beat_valid = 1'b0;
    logic [2:0]    beat_kind = '0;
    logic [AW-1:0] beat_addr = '0;
    logic [DW-1:0] mem_data = '0;
    logic [CW-1:0] mem_chk = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    wr_be = '0;
    logic          irq_en = 1'b0;
    logic          mchk_en = 1'b0;
    logic          scrub_wb_en = 1'b0;
    logic [2:0]    st_clr = '0;
    logic          bus_ack, rd_valid, wb_valid, irq, mchk, st_sbe, st_mbe, st_mck;
    logic [DW-1:0] rd_data, wb_data;
    logic [AW-1:0] wb_addr, st_addr;
    logic [CW-1:0] wb_chk, st_syn;
    logic [1:0]    st_cls;
    logic [2:0]    st_kind;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ecc_resp_ctrl #(.DATA_W(DW), .ADDR_W(AW), .LANE_W(8)) i_ecc_resp_ctrl (
        .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_kind(beat_kind),
        .beat_addr(beat_addr), .mem_data(mem_data), .mem_chk(mem_chk),
        .wr_data(wr_data), .wr_be(wr_be), .irq_en(irq_en), .mchk_en(mchk_en),
        .scrub_wb_en(scrub_wb_en), .st_clr(st_clr), .bus_ack(bus_ack),
        .rd_valid(rd_valid), .rd_data(rd_data), .wb_valid(wb_valid),
        .wb_addr(wb_addr), .wb_data(wb_data), .wb_chk(wb_chk), .irq(irq),
        .mchk(mchk), .st_sbe(st_sbe), .st_mbe(st_mbe), .st_mck(st_mck),
        .st_cls(st_cls), .st_kind(st_kind), .st_addr(st_addr), .st_syn(st_syn)
    );

    // reference encoder built from the R1 layout
    function automatic logic [CW-1:0] ref_enc(input logic [DW-1:0] d);
        logic [21:0]   w;
        logic [CW-1:0] c;
        int k;
        w = '0; c = '0; k = 0;
        for (int p = 1; p < 22; p++) begin
            if ((p & (p - 1)) != 0) begin
                w[p] = d[k];
                k++;
            end
        end
        for (int b = 0; b < 5; b++) begin
            for (int p = 1; p < 22; p++) begin
                if (((p >> b) & 1) == 1) c[b] = c[b] ^ w[p];
            end
        end
        c[5] = (^d) ^ (^c[4:0]);
        return c;
    endfunction

    function automatic logic [CW-1:0] ref_syn(input logic [DW-1:0] d, input logic [CW-1:0] c);
        logic [CW-1:0] r;
        r = ref_enc(d);
        return {(^d) ^ (^c), r[4:0] ^ c[4:0]};
    endfunction

    function automatic logic [DW-1:0] ref_merge(input logic [DW-1:0] old_w,
                                                input logic [DW-1:0] new_w,
                                                input logic [1:0] be);
        logic [DW-1:0] m;
        m[7:0]  = be[0] ? new_w[7:0]  : old_w[7:0];
        m[15:8] = be[1] ? new_w[15:8] : old_w[15:8];
        return m;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic beat(input logic [2:0] k, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [CW-1:0] c,
                        input logic [DW-1:0] w, input logic [1:0] be);
        @(negedge clk);
        beat_kind = k; beat_addr = a; mem_data = d; mem_chk = c;
        wr_data = w; wr_be = be; beat_valid = 1'b1;
        @(negedge clk);
        beat_valid = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        st_clr = 3'b111;
        @(negedge clk);
        st_clr = 3'b000;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [DW-1:0] pats [4];
        logic [21:0]   cw;
        logic [21:0]   cwf;
        logic [DW-1:0] bd [4];
        logic [CW-1:0] bc [4];
        logic [DW-1:0] bexp [4];
        pats[0] = 16'h0000; pats[1] = 16'hffff; pats[2] = 16'ha5c3; pats[3] = 16'h1234;

        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", "reset ack", bus_ack, 0);
        check("R12", "reset rd_valid", rd_valid, 0);
        check("R12", "reset wb_valid", wb_valid, 0);
        check("R12", "reset status", {st_sbe, st_mbe, st_mck, st_cls, st_addr, st_syn}, 0);
        check("R11", "reset irq/mchk", {irq, mchk}, 0);
        rst_n = 1'b1;
        irq_en = 1'b1; mchk_en = 1'b1; scrub_wb_en = 1'b1;

        // R2 R3: clean reads
        foreach (pats[n]) begin
            beat(3'd0, 8'h10, pats[n], ref_enc(pats[n]), '0, '0);
            check("R3", "clean rd_data", rd_data, pats[n]);
            check("R12", "clean rd_valid/ack", {rd_valid, bus_ack}, 2'b11);
            check("R2", "clean no flags", {st_sbe, st_mbe, irq}, 0);
        end

        // R2 R3 R10 R11: every single flip on reads
        foreach (pats[n]) begin
            for (int i = 0; i < 22; i++) begin
                cw  = {ref_enc(pats[n]), pats[n]};
                cwf = cw ^ (22'd1 << i);
                beat((i % 2 == 0) ? 3'd0 : 3'd1, 8'(i), cwf[15:0], cwf[21:16], '0, '0);
                check("R3", "single rd_data corrected", rd_data, pats[n]);
                check("R8", "single ack", bus_ack, 1);
                check("R2", "single class", st_cls, 1);
                check("R10", "single syndrome", st_syn, ref_syn(cwf[15:0], cwf[21:16]));
                check("R10", "single addr", st_addr, 8'(i));
                check("R11", "single irq, no mchk", {irq, mchk, st_sbe}, 3'b101);
                clear_all();
                check("R11", "irq after clear", {irq, st_sbe, st_cls}, 0);
            end
        end

        // R2 R4: every double flip on reads
        for (int n = 2; n < 4; n++) begin
            for (int i = 0; i < 22; i++) begin
                for (int j = i + 1; j < 22; j++) begin
                    cw  = {ref_enc(pats[n]), pats[n]};
                    cwf = cw ^ (22'd1 << i) ^ (22'd1 << j);
                    beat(3'd0, 8'h20, cwf[15:0], cwf[21:16], '0, '0);
                    check("R4", "double raw rd_data", rd_data, cwf[15:0]);
                    check("R2", "double class", st_cls, 2);
                    check("R4", "double mchk/irq", {mchk, irq, st_mck, st_mbe}, 4'b1111);
                    check("R8", "double ack", bus_ack, 1);
                    clear_all();
                end
            end
        end

        // R5 R1: read-modify-write, every byte enable and every single flip
        for (int be = 0; be < 4; be++) begin
            for (int i = -1; i < 22; i++) begin
                cw  = {ref_enc(16'h1234), 16'h1234};
                cwf = (i < 0) ? cw : cw ^ (22'd1 << i);
                beat(3'd2, 8'h30, cwf[15:0], cwf[21:16], 16'habcd, 2'(be));
                check("R5", "rmw wb_valid/addr", {wb_valid, wb_addr}, {1'b1, 8'h30});
                check("R5", "rmw merged data", wb_data, ref_merge(16'h1234, 16'habcd, 2'(be)));
                check("R1", "rmw check bits", wb_chk, ref_enc(ref_merge(16'h1234, 16'habcd, 2'(be))));
                check("R8", "rmw ack", bus_ack, 1);
                clear_all();
            end
        end

        // R6: read-modify-write with double error
        for (int i = 0; i < 22; i += 3) begin
            cw  = {ref_enc(16'h5a5a), 16'h5a5a};
            cwf = cw ^ (22'd1 << i) ^ (22'd1 << ((i + 7) % 22));
            beat(3'd2, 8'h31, cwf[15:0], cwf[21:16], 16'hffff, 2'b11);
            check("R6", "rmw double no write-back", wb_valid, 0);
            check("R6", "rmw double ack/mchk/kind", {bus_ack, mchk, st_kind}, {2'b11, 3'd2});
            clear_all();
        end

        // R7: scrub
        cw  = {ref_enc(16'hc0de), 16'hc0de};
        cwf = cw ^ (22'd1 << 9);
        beat(3'd4, 8'h40, cwf[15:0], cwf[21:16], '0, '0);
        check("R7", "scrub single write-back", {wb_valid, wb_addr, wb_data, wb_chk},
              {1'b1, 8'h40, 16'hc0de, ref_enc(16'hc0de)});
        check("R7", "scrub no ack/rd", {bus_ack, rd_valid}, 0);
        check("R7", "scrub irq, no mchk", {irq, mchk, st_mck}, 3'b100);
        clear_all();
        scrub_wb_en = 1'b0;
        beat(3'd4, 8'h41, cwf[15:0], cwf[21:16], '0, '0);
        check("R7", "scrub write-back disabled", wb_valid, 0);
        check("R7", "scrub disabled still flags", {irq, st_sbe}, 2'b11);
        clear_all();
        scrub_wb_en = 1'b1;
        cwf = cw ^ (22'd1 << 2) ^ (22'd1 << 17);
        beat(3'd4, 8'h42, cwf[15:0], cwf[21:16], '0, '0);
        check("R7", "scrub double no write-back", {wb_valid, bus_ack}, 0);
        check("R7", "scrub double no mchk", {irq, st_mbe, st_mck, mchk}, 4'b1100);
        clear_all();

        // R8 R1: full-line write ignores the memory word
        beat(3'd3, 8'h50, 16'hdead, 6'h3f, 16'h7e81, 2'b00);
        check("R8", "line write data", {bus_ack, wb_valid, wb_data}, {2'b11, 16'h7e81});
        check("R1", "line write check bits", wb_chk, ref_enc(16'h7e81));
        check("R8", "line write unchecked", {st_sbe, st_mbe, irq}, 0);

        // R9 R10: line read with mixed classes
        bd[0] = 16'h1111; bc[0] = ref_enc(16'h1111); bexp[0] = 16'h1111;
        cw = {ref_enc(16'h2222), 16'h2222}; cwf = cw ^ (22'd1 << 3);
        bd[1] = cwf[15:0]; bc[1] = cwf[21:16]; bexp[1] = 16'h2222;
        cw = {ref_enc(16'h3333), 16'h3333}; cwf = cw ^ 22'd1 ^ (22'd1 << 5);
        bd[2] = cwf[15:0]; bc[2] = cwf[21:16]; bexp[2] = cwf[15:0];
        cw = {ref_enc(16'h4444), 16'h4444}; cwf = cw ^ (22'd1 << 18);
        bd[3] = cwf[15:0]; bc[3] = cwf[21:16]; bexp[3] = 16'h4444;
        for (int b = 0; b < 5; b++) begin
            @(negedge clk);
            if (b > 0) check("R9", "burst beat data", rd_data, bexp[b-1]);
            if (b < 4) begin
                beat_kind = 3'd1; beat_addr = 8'(8'h60 + b); mem_data = bd[b];
                mem_chk = bc[b]; beat_valid = 1'b1;
            end else begin
                beat_valid = 1'b0;
            end
        end
        check("R9", "burst worst class", st_cls, 2);
        check("R10", "burst held addr/kind", {st_addr, st_kind}, {8'h62, 3'd1});
        check("R9", "burst flags", {st_sbe, st_mbe, irq, mchk}, 4'b1111);

        // R11: enables gate levels, partial clears
        @(negedge clk);
        irq_en = 1'b0; mchk_en = 1'b0;
        #1 check("R11", "enables off", {irq, mchk}, 0);
        irq_en = 1'b1; mchk_en = 1'b1;
        #1 check("R11", "enables on, level held", {irq, mchk}, 2'b11);
        @(negedge clk); st_clr = 3'b010; @(negedge clk); st_clr = 3'b000;
        check("R11", "clear mbe only", {st_sbe, st_mbe, irq, mchk}, 4'b1011);
        @(negedge clk); st_clr = 3'b100; @(negedge clk); st_clr = 3'b000;
        check("R11", "clear mck", {irq, mchk}, 2'b10);
        @(negedge clk); st_clr = 3'b001; @(negedge clk); st_clr = 3'b000;
        check("R10", "all cleared class", {irq, st_cls}, 0);

        // R11: set wins over clear in the same cycle
        cw = {ref_enc(16'h0f0f), 16'h0f0f}; cwf = cw ^ (22'd1 << 6);
        @(negedge clk);
        beat_kind = 3'd0; beat_addr = 8'h70; mem_data = cwf[15:0]; mem_chk = cwf[21:16];
        beat_valid = 1'b1; st_clr = 3'b111;
        @(negedge clk);
        beat_valid = 1'b0; st_clr = 3'b000;
        check("R11", "set beats clear", {st_sbe, irq, st_addr}, {2'b11, 8'h70});

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule